// File: doc/BRIEF.md
# Stream-to-Memory Ring Writer

This block takes words from a valid/ready input stream and writes each one into a ring buffer held in external memory. The memory is reached through a write port with two channels. The command channel carries valid, ready, a write-enable bit and an address. The data channel carries valid, ready and the data word. A small ring controller inside the block keeps the write pointer and the fill level. The pointer supplies the target address, which is `BASE` plus the pointer.

Each word goes through two steps. First a command is issued, and the input word is taken on the same cycle the command is accepted. The data is then offered on the following cycle and held until memory accepts it. On that data handshake the word counts as committed: the pointer advances and the level rises by one. A consumer-side pop strobe lowers the level. When the level reaches the write threshold, the block stops taking input until a pop frees room. A threshold above the ring depth allows older entries to be overwritten as the pointer wraps.

Top module: `ring_wr_top`

## Requirements
- R1: After reset, sink_ready_o, cmd_valid_o, wdata_valid_o and wr_commit_o are 0, and level_o is 0.
- R2: The n-th accepted word, counting from 0 after reset, is written to address BASE + (n mod DEPTH). The pointer wraps from DEPTH-1 to 0.
- R3: cmd_valid_o is high only while no word is in flight, sink_valid_i is high and level_o < WR_THRESH. cmd_we_o equals 1 whenever cmd_valid_o is high.
- R4: The data word appears on wdata_o with wdata_valid_o high on the cycle after the command handshake. It stays stable until the cycle wdata_ready_i is high.
- R5: sink_ready_o is high only on the cycle the command handshake completes. Each input word is written exactly once and in order, and no new word is taken while a word is in flight.
- R6: wr_commit_o pulses for exactly one cycle per word, on the data-handshake cycle. On the following cycle level_o is one higher, unless a pop occurs in the same cycle.
- R7: While level_o >= WR_THRESH, sink_ready_o and cmd_valid_o stay low no matter how long the input stays valid and the command channel stays ready.
- R8: A one-cycle rd_pop_i lowers level_o by one on the next cycle. A pop at level 0 is ignored. A pop on the same cycle as a commit leaves the level unchanged.
- R9: With WR_THRESH > DEPTH, writing continues past DEPTH words and later words overwrite earlier ring locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sink_valid_i | input | 1 | Input word valid |
| sink_ready_o | output | 1 | Input word taken |
| sink_data_i | input | DATA_W | Input word |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by memory |
| cmd_we_o | output | 1 | Command is a write |
| cmd_addr_o | output | ADDR_W | Command address |
| wdata_valid_o | output | 1 | Write data valid |
| wdata_ready_i | input | 1 | Write data accepted by memory |
| wdata_o | output | DATA_W | Write data |
| rd_pop_i | input | 1 | Consumer freed one entry |
| wr_commit_o | output | 1 | Word committed this cycle |
| level_o | output | $clog2(WR_THRESH+1) | Committed fill level |

## Verification
The bench inserts stalls on both memory channels. A design that took the input word before the command was accepted, or that let the data change during a stall, would write wrong or duplicated words into the memory model. The bench pushes more words than the ring depth, so a pointer that failed to wrap or that wrapped at the wrong point would leave the wrong word at the low addresses. It keeps the input valid for many cycles at the threshold and expects a full stall. It also drives a pop at level zero and a pop on a commit cycle, where a naive level counter would underflow or double-count.

// File: rtl/ring_wr_pkg.sv
package ring_wr_pkg;
  typedef enum logic {ST_CMD, ST_DATA} wr_state_e;
endpackage

// File: rtl/ring_wr_ctrl.sv
module ring_wr_ctrl #(
  parameter int DEPTH     = 16,
  parameter int WR_THRESH = 16,
  parameter int BASE      = 0,
  parameter int ADDR_W    = 32,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W    = $clog2(WR_THRESH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              writable_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             pop_eff;

  assign pop_eff = pop_i && (level_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      level_q <= '0;
    end else begin
      if (push_i) ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      case ({push_i, pop_eff})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign wr_addr_o  = ADDR_W'(BASE) + ADDR_W'(ptr_q);
  assign level_o    = level_q;
  assign writable_o = level_q < LVL_W'(WR_THRESH);

  a_r7_level_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(WR_THRESH));
  a_r8_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && level_q == '0) |=> level_q == '0);
endmodule

// File: rtl/ring_wr_path.sv
module ring_wr_path
  import ring_wr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sink_valid_i,
  input  logic [DATA_W-1:0] sink_data_i,
  output logic              sink_ready_o,
  input  logic              writable_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wdata_valid_o,
  input  logic              wdata_ready_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              commit_o
);
  wr_state_e         state_q;
  logic [DATA_W-1:0] data_q;
  logic              cmd_hs;

  assign cmd_valid_o   = (state_q == ST_CMD) && sink_valid_i && writable_i;
  assign cmd_we_o      = cmd_valid_o;
  assign cmd_addr_o    = addr_i;
  assign cmd_hs        = cmd_valid_o && cmd_ready_i;
  assign sink_ready_o  = cmd_hs;
  assign wdata_valid_o = (state_q == ST_DATA);
  assign wdata_o       = data_q;
  assign commit_o      = wdata_valid_o && wdata_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      data_q  <= '0;
    end else if (cmd_hs) begin
      state_q <= ST_DATA;
      data_q  <= sink_data_i;
    end else if (commit_o) begin
      state_q <= ST_CMD;
    end
  end

  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdata_valid_o && !wdata_ready_i) |=> (wdata_valid_o && $stable(wdata_o)));
  a_r4_data_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i) |=> wdata_valid_o);
  a_r5_one_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sink_ready_o |-> !wdata_valid_o);
endmodule

// File: rtl/ring_wr_top.sv
module ring_wr_top #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BASE      = 8,
  parameter int DEPTH     = 16,
  parameter int WR_THRESH = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               sink_valid_i,
  output logic                               sink_ready_o,
  input  logic [DATA_W-1:0]                  sink_data_i,
  output logic                               cmd_valid_o,
  input  logic                               cmd_ready_i,
  output logic                               cmd_we_o,
  output logic [ADDR_W-1:0]                  cmd_addr_o,
  output logic                               wdata_valid_o,
  input  logic                               wdata_ready_i,
  output logic [DATA_W-1:0]                  wdata_o,
  input  logic                               rd_pop_i,
  output logic                               wr_commit_o,
  output logic [$clog2(WR_THRESH+1)-1:0]     level_o
);
  localparam int LVL_W = $clog2(WR_THRESH + 1);

  logic [ADDR_W-1:0] wr_addr;
  logic              writable;

  ring_wr_ctrl #(
    .DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .BASE(BASE), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk_i, .rst_ni,
    .push_i    (wr_commit_o),
    .pop_i     (rd_pop_i),
    .wr_addr_o (wr_addr),
    .level_o   (level_o),
    .writable_o(writable)
  );

  ring_wr_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) path_i (
    .clk_i, .rst_ni,
    .sink_valid_i, .sink_data_i, .sink_ready_o,
    .writable_i   (writable),
    .addr_i       (wr_addr),
    .cmd_valid_o, .cmd_ready_i, .cmd_we_o, .cmd_addr_o,
    .wdata_valid_o, .wdata_ready_i, .wdata_o,
    .commit_o     (wr_commit_o)
  );

  a_r3_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !writable |-> !cmd_valid_o);
  a_r2_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_addr_o >= ADDR_W'(BASE) && cmd_addr_o < ADDR_W'(BASE + DEPTH)));
  a_r6_level_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_commit_o && !rd_pop_i) |=> level_o == LVL_W'($past(level_o) + 1'b1));
endmodule

// File: tb/ring_wr_top_tb_top.sv
module ring_wr_top_tb_top;
  localparam int DW = 32, AW = 32, BASE = 8, DEPTH = 8, THR = 12;
  localparam int LW = $clog2(THR + 1);

  logic clk = 0, rst_n = 0;
  logic sink_valid = 0, cmd_ready = 0, wdata_ready = 0, rd_pop = 0;
  logic [DW-1:0] sink_data = '0;
  logic sink_ready, cmd_valid, cmd_we, wdata_valid, commit;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wdata;
  logic [LW-1:0] level;

  always #5 clk = ~clk;

  ring_wr_top #(.DATA_W(DW), .ADDR_W(AW), .BASE(BASE), .DEPTH(DEPTH), .WR_THRESH(THR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sink_valid_i(sink_valid), .sink_ready_o(sink_ready), .sink_data_i(sink_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .wdata_valid_o(wdata_valid), .wdata_ready_i(wdata_ready), .wdata_o(wdata),
    .rd_pop_i(rd_pop), .wr_commit_o(commit), .level_o(level)
  );

  // memory model
  logic [DW-1:0] mem [0:31];
  logic [AW-1:0] lat_addr;
  int            n_writes = 0;
  always @(posedge clk) begin
    if (cmd_valid && cmd_ready) lat_addr <= cmd_addr;
    if (wdata_valid && wdata_ready) begin
      mem[lat_addr[4:0]] <= wdata;
      n_writes <= n_writes + 1;
    end
  end

  int n_chk = 0, n_err = 0;
  int n_word = 0;
  int exp_lvl = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stimulus table: data, command stall, data stall, pop on commit
  typedef struct packed { logic [31:0] d; logic [3:0] cd; logic [3:0] wd; logic pop; } vec_t;
  localparam vec_t VECS [0:9] = '{
    '{32'hA000_0000, 4'd0, 4'd0, 1'b0}, '{32'hA000_0001, 4'd2, 4'd0, 1'b0},
    '{32'hA000_0002, 4'd0, 4'd3, 1'b0}, '{32'hA000_0003, 4'd1, 4'd1, 1'b0},
    '{32'hA000_0004, 4'd3, 4'd2, 1'b0}, '{32'hA000_0005, 4'd0, 4'd0, 1'b0},
    '{32'hA000_0006, 4'd0, 4'd5, 1'b0}, '{32'hA000_0007, 4'd4, 4'd0, 1'b0},
    '{32'hB000_0008, 4'd1, 4'd0, 1'b0}, '{32'hB000_0009, 4'd0, 4'd2, 1'b0}};

  task automatic push(input logic [31:0] d, input int cd, input int wd, input bit pop);
    int exp_addr;
    exp_addr = BASE + (n_word % DEPTH);
    @(negedge clk);
    sink_valid = 1; sink_data = d; cmd_ready = 0;
    #1;
    chk(cmd_valid && cmd_we, "R3", cmd_valid, 1);
    chk(cmd_addr == AW'(exp_addr), "R2", cmd_addr, exp_addr);
    chk(!sink_ready, "R5", sink_ready, 0);
    for (int i = 0; i < cd; i++) begin
      @(negedge clk); #1;
      chk(cmd_valid && !sink_ready && cmd_addr == AW'(exp_addr), "R5", sink_ready, 0);
    end
    cmd_ready = 1; #1;
    chk(sink_ready, "R5", sink_ready, 1);
    @(negedge clk);
    sink_valid = 0; cmd_ready = 0; sink_data = 32'hDEAD_BEEF;
    #1;
    chk(wdata_valid && wdata == d, "R4", wdata, d);
    chk(!cmd_valid && !sink_ready, "R5", cmd_valid, 0);
    for (int i = 0; i < wd; i++) begin
      @(negedge clk); #1;
      chk(wdata_valid && wdata == d && !commit, "R4", wdata, d);
    end
    wdata_ready = 1; rd_pop = pop; #1;
    chk(commit, "R6", commit, 1);
    @(negedge clk);
    wdata_ready = 0; rd_pop = 0; #1;
    if (!pop) exp_lvl++;
    n_word++;
    chk(!commit && !wdata_valid, "R6", commit, 0);
    chk(level == LW'(exp_lvl), "R6", level, exp_lvl);
  endtask

  task automatic pop1();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0; #1;
    if (exp_lvl > 0) exp_lvl--;
    chk(level == LW'(exp_lvl), "R8", level, exp_lvl);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    chk(!sink_ready && !cmd_valid && !wdata_valid && !commit && level == 0, "R1", level, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!sink_ready && !cmd_valid && !wdata_valid && !commit && level == 0, "R1", level, 0);
    // R3: no input, no command
    cmd_ready = 1;
    repeat (3) begin @(negedge clk); #1; chk(!cmd_valid && !sink_ready, "R3", cmd_valid, 0); end
    cmd_ready = 0;

    foreach (VECS[k]) push(VECS[k].d, int'(VECS[k].cd), int'(VECS[k].wd), VECS[k].pop);

    // R9 / R2: wrap overwrote first two slots
    @(negedge clk);
    chk(mem[8] == 32'hB000_0008, "R9", mem[8], 32'hB000_0008);
    chk(mem[9] == 32'hB000_0009, "R9", mem[9], 32'hB000_0009);
    for (int a = 2; a < 8; a++)
      chk(mem[8 + a] == (32'hA000_0000 + a), "R2", mem[8 + a], 32'hA000_0000 + a);
    chk(n_writes == 10, "R5", n_writes, 10);

    push(32'hC000_000A, 0, 0, 1'b0);
    push(32'hC000_000B, 1, 1, 1'b0);
    chk(level == LW'(THR), "R7", level, THR);

    // R7: full stall
    @(negedge clk);
    sink_valid = 1; sink_data = 32'hEEEE_0001; cmd_ready = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      chk(!sink_ready && !cmd_valid, "R7", sink_ready, 0);
    end
    sink_valid = 0; cmd_ready = 0;

    pop1();
    push(32'hD000_000C, 0, 1, 1'b0);   // room again after pop
    // R8: pop together with commit keeps level
    pop1(); pop1();
    push(32'hD000_000D, 1, 2, 1'b1);
    chk(level == LW'(exp_lvl), "R8", level, exp_lvl);

    while (exp_lvl > 0) pop1();
    pop1();   // R8: pop at zero ignored
    chk(level == 0, "R8", level, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule